// File: doc/BRIEF.md
# Readout Instruction Sequencer

This block runs a short program of 20-bit instructions held in an on-block instruction memory. A host fills the memory through a write port and pulses a start input. The sequencer then fetches and decodes the instructions one after another. For each frontend operation it raises a request to a frontend bus controller, presenting the opcode and the 16-bit operand. The controller answers with a one-cycle acknowledge. Between those operations the program can stall for a counted number of cycles, block until an external trigger arrives, repeat a block of instructions with a counted or endless jump, and finish with an end instruction.

Every instruction takes one fetch cycle and one decode cycle. Stalls and bus waits add their own cycles on top. An undefined opcode halts the program and raises a sticky error. A stop input lets the host abandon a program that is parked in a counted stall or a trigger stall. Only one loop counter exists. A jump that falls through disarms it, so the next jump it meets reloads the counter from that jump's own count.

Top module: `readout_sequencer`

## Requirements
- R1: After reset, busy, done, illegalOp and feReq are all 0, and feReq is never 1 while busy is 0.
- R2: A one-cycle start pulse sets the program counter to 0, clears done, illegalOp and the loop counter, and makes busy 1 from the next cycle. Writing hostWrData to address hostWrAddr while hostWrEn is 1 loads the instruction memory.
- R3: The opcode is instruction bits [19:16]. The opcodes 0x3 (channel readout), 0x4 (register read), 0x5 (register write), 0x6 (status clear), 0x7 (pedestal read), 0x8 (pedestal write; bit 12 is broadcast, bits [11:0] are the channel), 0x9 (L2 counter clear) and 0xA (L1 counter clear) raise feReq with feOp equal to the opcode and feArg equal to bits [15:0]. These stay steady until feAck is seen, and then execution moves to the next address.
- R4: Opcode 0x0 is a jump, with the count N in bits [15:8] and the target address in bits [7:0]. With N greater than 0, the jump is taken N times and then falls through, so the preceding block runs N+1 times. Falling through disarms the counter, so a later jump loads its own count afresh.
- R5: A jump with a count of 0 is taken every time it is met, forever.
- R6: Opcode 0xB with value W in bits [15:0] stalls for W cycles after its decode cycle before the next fetch. W = 0 adds no stall.
- R7: Opcode 0x1 holds execution until trigIn is seen high. The next fetch starts in the cycle after that.
- R8: A stop input that is high during a counted stall or a trigger stall returns the block to idle, with done and illegalOp left at 0.
- R9: Opcode 0x2 ends the program. busy falls and done rises, and done stays high until the next start.
- R10: Opcodes 0xC to 0xF halt the program and set illegalOp, which stays set until the next start. No further requests are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Instruction memory write enable |
| hostWrAddr | input | ADDR_W | Instruction memory write address |
| hostWrData | input | 20 | Instruction word to store |
| start | input | 1 | Start pulse: restart from address 0 |
| stop | input | 1 | Abort a counted or trigger stall |
| trigIn | input | 1 | External trigger level |
| feAck | input | 1 | Bus controller acknowledge pulse |
| feReq | output | 1 | Frontend operation request |
| feOp | output | 4 | Opcode of the requested operation |
| feArg | output | 16 | Operand of the requested operation |
| busy | output | 1 | Program running |
| done | output | 1 | Program reached an end instruction |
| illegalOp | output | 1 | Sticky undefined-opcode flag |

## Verification
A wrong program counter or loop counter shows up in the order and number of frontend requests. This shows within one instruction time, which is three cycles for an immediately acknowledged operation. A wrong stall counter shows up as a gap between two acknowledges that differs from W+5 cycles. A wrong disarm shows up only at the next jump that is met, as a missing repetition. A bad flag or state shows at once on busy, done or illegalOp when the program ends.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int INSTR_W = 20;
  localparam int OP_W    = 4;
  localparam int ARG_W   = 16;
  localparam int LOOP_W  = 8;
  localparam int WAIT_W  = 16;

  localparam logic [3:0] OP_JUMP = 4'h0;
  localparam logic [3:0] OP_TRIG = 4'h1;
  localparam logic [3:0] OP_END  = 4'h2;
  localparam logic [3:0] OP_CHRD = 4'h3;
  localparam logic [3:0] OP_RGRD = 4'h4;
  localparam logic [3:0] OP_RGWR = 4'h5;
  localparam logic [3:0] OP_CLST = 4'h6;
  localparam logic [3:0] OP_PMRD = 4'h7;
  localparam logic [3:0] OP_PMWR = 4'h8;
  localparam logic [3:0] OP_CLL2 = 4'h9;
  localparam logic [3:0] OP_CLL1 = 4'hA;
  localparam logic [3:0] OP_WAIT = 4'hB;

  typedef struct packed {
    logic pcClear;
    logic pcInc;
    logic pcLoad;
    logic loopArm;
    logic loopDec;
    logic loopDisarm;
    logic waitLoad;
    logic waitDec;
    logic irLoad;
  } dpCtrl_t;

  typedef struct packed {
    logic [OP_W-1:0] opcode;
    logic loopActive;
    logic loopZero;
    logic loopFieldZero;
    logic waitFieldZero;
    logic waitLast;
  } dpStat_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic                hostWrEn,
  input  logic [ADDR_W-1:0]   hostWrAddr,
  input  logic [INSTR_W-1:0]  hostWrData,
  output dpStat_t             stat,
  output logic [INSTR_W-1:0]  instr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [INSTR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]  pc;
  logic [LOOP_W-1:0]  loopCnt;
  logic               loopActive;
  logic [WAIT_W-1:0]  waitCnt;

  always_ff @(posedge clk) begin
    if (hostWrEn) mem[hostWrAddr] <= hostWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) instr <= '0;
    else if (ctrl.irLoad) instr <= mem[pc];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else if (ctrl.pcClear) pc <= '0;
    else if (ctrl.pcLoad) pc <= instr[ADDR_W-1:0];
    else if (ctrl.pcInc) pc <= pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopCnt    <= '0;
      loopActive <= 1'b0;
    end else if (ctrl.pcClear || ctrl.loopDisarm) begin
      loopCnt    <= '0;
      loopActive <= 1'b0;
    end else if (ctrl.loopArm) begin
      loopCnt    <= instr[15:8] - 1'b1;
      loopActive <= 1'b1;
    end else if (ctrl.loopDec) begin
      loopCnt    <= loopCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (ctrl.waitLoad) waitCnt <= instr[WAIT_W-1:0];
    else if (ctrl.waitDec) waitCnt <= waitCnt - 1'b1;
  end

  always_comb begin
    stat.opcode        = instr[INSTR_W-1 -: OP_W];
    stat.loopActive    = loopActive;
    stat.loopZero      = (loopCnt == '0);
    stat.loopFieldZero = (instr[15:8] == '0);
    stat.waitFieldZero = (instr[WAIT_W-1:0] == '0);
    stat.waitLast      = (waitCnt == WAIT_W'(1));
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    stop,
  input  logic    trigIn,
  input  logic    feAck,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    feReq,
  output logic    busy,
  output logic    done,
  output logic    illegalOp
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_STALL, S_TRIG, S_BUS
  } state_e;

  state_e state, nextState;
  logic   setDone, setErr;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    setDone   = 1'b0;
    setErr    = 1'b0;
    if (start) begin
      ctrl.pcClear = 1'b1;
      nextState    = S_FETCH;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_FETCH: begin
          ctrl.irLoad = 1'b1;
          nextState   = S_EXEC;
        end
        S_EXEC: begin
          nextState = S_FETCH;
          case (stat.opcode)
            OP_JUMP: begin
              if (!stat.loopActive) begin
                ctrl.pcLoad  = 1'b1;
                ctrl.loopArm = !stat.loopFieldZero;
              end else if (stat.loopZero) begin
                ctrl.pcInc      = 1'b1;
                ctrl.loopDisarm = 1'b1;
              end else begin
                ctrl.pcLoad  = 1'b1;
                ctrl.loopDec = 1'b1;
              end
            end
            OP_WAIT: begin
              if (stat.waitFieldZero) ctrl.pcInc = 1'b1;
              else begin
                ctrl.waitLoad = 1'b1;
                nextState     = S_STALL;
              end
            end
            OP_TRIG: nextState = S_TRIG;
            OP_END: begin
              setDone   = 1'b1;
              nextState = S_IDLE;
            end
            OP_CHRD, OP_RGRD, OP_RGWR, OP_CLST,
            OP_PMRD, OP_PMWR, OP_CLL2, OP_CLL1: nextState = S_BUS;
            default: begin
              setErr    = 1'b1;
              nextState = S_IDLE;
            end
          endcase
        end
        S_STALL: begin
          if (stop) nextState = S_IDLE;
          else if (stat.waitLast) begin
            ctrl.pcInc = 1'b1;
            nextState  = S_FETCH;
          end else ctrl.waitDec = 1'b1;
        end
        S_TRIG: begin
          if (stop) nextState = S_IDLE;
          else if (trigIn) begin
            ctrl.pcInc = 1'b1;
            nextState  = S_FETCH;
          end
        end
        S_BUS: begin
          if (feAck) begin
            ctrl.pcInc = 1'b1;
            nextState  = S_FETCH;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      state <= nextState;
      if (start) begin
        done      <= 1'b0;
        illegalOp <= 1'b0;
      end else begin
        if (setDone) done <= 1'b1;
        if (setErr) illegalOp <= 1'b1;
      end
    end
  end

  assign feReq = (state == S_BUS);
  assign busy  = (state != S_IDLE);
endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [19:0]       hostWrData,
  input  logic              start,
  input  logic              stop,
  input  logic              trigIn,
  input  logic              feAck,
  output logic              feReq,
  output logic [3:0]        feOp,
  output logic [15:0]       feArg,
  output logic              busy,
  output logic              done,
  output logic              illegalOp
);
  dpCtrl_t            ctrl;
  dpStat_t            stat;
  logic [INSTR_W-1:0] instr;

  seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .trigIn(trigIn),
    .feAck(feAck), .stat(stat), .ctrl(ctrl), .feReq(feReq), .busy(busy),
    .done(done), .illegalOp(illegalOp)
  );

  seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .hostWrEn(hostWrEn),
    .hostWrAddr(hostWrAddr), .hostWrData(hostWrData), .stat(stat),
    .instr(instr)
  );

  assign feOp  = instr[INSTR_W-1 -: OP_W];
  assign feArg = instr[ARG_W-1:0];
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        feAck,
  input logic        feReq,
  input logic [3:0]  feOp,
  input logic [15:0] feArg,
  input logic        busy,
  input logic        done,
  input logic        illegalOp
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !feReq);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy && !illegalOp && !done);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    feReq && !feAck && !start |=> feReq && $stable(feOp) && $stable(feArg));

  p_ack_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    feReq && feAck && !start |=> !feReq);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !illegalOp);

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !busy && !feReq);
endmodule

bind readout_sequencer seq_checker u_chk (.*);

// File: tb/tb_readout_sequencer.sv
`timescale 1ns/1ps
module tb_readout_sequencer;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [ADDR_W-1:0] hostWrAddr = '0;
  logic [19:0] hostWrData = '0;
  logic start = 1'b0, stop = 1'b0, trigIn = 1'b0, feAck = 1'b0;
  logic feReq, busy, done, illegalOp;
  logic [3:0] feOp;
  logic [15:0] feArg;

  readout_sequencer #(.ADDR_W(ADDR_W)) dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int logN = 0, reqHigh = 0, holdCnt = 0, ackDelay = 0;
  int logOp [64];
  int logArg [64];
  int logTime [64];

  always @(negedge clk) begin
    if (feReq) reqHigh++;
    if (feAck) feAck = 1'b0;
    else if (feReq) begin
      if (holdCnt == ackDelay) begin
        feAck = 1'b1;
        holdCnt = 0;
        if (logN < 64) begin
          logOp[logN] = int'(feOp);
          logArg[logN] = int'(feArg);
          logTime[logN] = cyc;
        end
        logN++;
      end else holdCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] ins(input logic [3:0] op, input logic [15:0] f);
    return {op, f};
  endfunction

  task automatic wr(input int a, input logic [19:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrAddr = ADDR_W'(a); hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic kick();
    logN = 0; reqHigh = 0; holdCnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runToIdle();
    kick();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 illegalOp", illegalOp, 0);
    chk("R1 feReq", feReq, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R9: every frontend opcode in sequence
    begin
      logic [3:0] ops [8] = '{4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA};
      for (int k = 0; k < 8; k++) wr(k, ins(ops[k], 16'(16'h1100 * k + 16'h0123)));
      wr(8, ins(4'h2, 16'h0));
      runToIdle();
      chk("R3 request count", logN, 8);
      for (int k = 0; k < 8; k++) begin
        chk("R3 feOp", logOp[k], int'(ops[k]));
        chk("R3 feArg", logArg[k], 'h1100 * k + 'h0123);
      end
      chk("R9 done", done, 1);
      chk("R9 busy", busy, 0);
    end

    // R4: counted loop sweep
    for (int n = 1; n <= 5; n++) begin
      wr(0, ins(4'h3, 16'h0010));
      wr(1, ins(4'h0, 16'((n << 8) | 0)));
      wr(2, ins(4'h3, 16'h0020));
      wr(3, ins(4'h2, 16'h0));
      runToIdle();
      cnt = 0;
      for (int k = 0; k < logN && k < 64; k++) if (logArg[k] == 'h10) cnt++;
      chk("R4 body repetitions", cnt, n + 1);
      chk("R4 total requests", logN, n + 2);
      chk("R4 fall-through op", logArg[n + 1], 'h20);
    end

    // R4: disarm after fall-through, second loop reloads
    wr(0, ins(4'h3, 16'h00A1));
    wr(1, ins(4'h0, 16'h0200));
    wr(2, ins(4'h3, 16'h00B2));
    wr(3, ins(4'h3, 16'h00C3));
    wr(4, ins(4'h0, 16'h0103));
    wr(5, ins(4'h2, 16'h0));
    runToIdle();
    chk("R4 rearm total", logN, 6);
    chk("R4 rearm fifth", logArg[4], 'hC3);
    chk("R4 rearm sixth", logArg[5], 'hC3);

    // R6: wait length sweep, gap between acks is W+5
    begin
      int ws [5] = '{0, 1, 2, 7, 300};
      for (int k = 0; k < 5; k++) begin
        wr(0, ins(4'h3, 16'h0001));
        wr(1, ins(4'hB, 16'(ws[k])));
        wr(2, ins(4'h3, 16'h0002));
        wr(3, ins(4'h2, 16'h0));
        runToIdle();
        chk("R6 requests", logN, 2);
        chk("R6 gap", logTime[1] - logTime[0], ws[k] + 5);
      end
    end

    // R5 endless jump, R8 stop inside the wait
    wr(0, ins(4'h3, 16'h00AA));
    wr(1, ins(4'hB, 16'h0003));
    wr(2, ins(4'h0, 16'h0000));
    kick();
    for (int i = 0; i < 2000 && logN < 12; i++) @(negedge clk);
    chk("R5 endless loop still busy", busy, 1);
    chk("R5 many repetitions", int'(logN >= 12), 1);
    stop = 1'b1;
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    stop = 1'b0;
    chk("R8 stop from wait busy", busy, 0);
    chk("R8 stop from wait done", done, 0);
    chk("R8 stop from wait illegalOp", illegalOp, 0);

    // R7: trigger stall
    wr(0, ins(4'h1, 16'h0));
    wr(1, ins(4'h3, 16'h0005));
    wr(2, ins(4'h2, 16'h0));
    kick();
    repeat (30) @(negedge clk);
    chk("R7 no request before trigger", logN, 0);
    chk("R7 busy while stalled", busy, 1);
    begin
      int tTrig;
      trigIn = 1'b1; tTrig = cyc;
      @(negedge clk); trigIn = 1'b0;
      for (int i = 0; i < 50 && busy; i++) @(negedge clk);
      chk("R7 request after trigger", logN, 1);
      chk("R7 trigger latency", logTime[0] - tTrig, 3);
      chk("R7 arg", logArg[0], 5);
    end

    // R8: stop from trigger stall
    kick();
    repeat (10) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    @(negedge clk);
    chk("R8 stop from trigger busy", busy, 0);
    chk("R8 stop from trigger done", done, 0);
    chk("R8 stop from trigger requests", logN, 0);

    // R10: undefined opcodes
    for (int op = 12; op < 16; op++) begin
      wr(0, ins(4'h3, 16'h0001));
      wr(1, ins(4'(op), 16'h0000));
      wr(2, ins(4'h3, 16'h0002));
      wr(3, ins(4'h2, 16'h0));
      runToIdle();
      repeat (5) @(negedge clk);
      chk("R10 requests before halt", logN, 1);
      chk("R10 illegalOp", illegalOp, 1);
      chk("R10 busy", busy, 0);
      chk("R10 done", done, 0);
    end
    // R2: start clears the sticky error
    wr(1, ins(4'h2, 16'h0));
    runToIdle();
    chk("R2 error cleared", illegalOp, 0);
    chk("R2 run completes", done, 1);

    // R3: slow acknowledge, broadcast pedestal write
    ackDelay = 4;
    wr(0, ins(4'h8, 16'h1ABC));
    wr(1, ins(4'h2, 16'h0));
    runToIdle();
    ackDelay = 0;
    chk("R3 held request cycles", reqHigh, 5);
    chk("R3 single request", logN, 1);
    chk("R3 broadcast bit", (logArg[0] >> 12) & 1, 1);
    chk("R3 channel", logArg[0] & 'hFFF, 'hABC);
    chk("R3 pedestal write op", logOp[0], 8);

    summary();
  end
endmodule